// File: doc/BRIEF.md
# Checksum-Neutral Transmit Timestamp Injector

This block sits in a transmit byte pipeline, one byte per cycle, and writes a 64-bit transmit timestamp into a 10-byte hole in the frame. The application leaves that hole zero-filled. The block puts a 16-bit correction word in the first two bytes of the hole and the timestamp, most significant byte first, in the next eight. The correction is picked so that the ones'-complement sum of the ten bytes is negative zero (0xFFFF). Any IPv4, UDP or TCP checksum that covers the hole therefore stays valid, and nothing downstream has to recompute it.

The write position is computed once per frame, at the first byte. It is a chosen anchor plus a signed static offset. The anchor is the frame start, the frame end, the layer 3 header start or the layer 4 header start. The position is checked before use:

- It must be even relative to the start of the checksummed region.
- It must leave room for the ten injected bytes and a four-byte FCS before the frame end.

If either check fails, the frame goes out untouched and a one-cycle error pulse comes out with its first byte.

Injection is requested per frame by a metadata bit, or for every frame by a global configuration bit. The stamp is either the time of the first byte or the time of the last byte. The last-byte time is derived from the frame length, on the assumption that the frame moves at one byte per cycle.

Top module: `tsinj_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, outValid, outSof, outEof and injErr are low.
- R2: Every input byte reappears exactly one cycle later, with the same valid, start and end flags. Bytes outside the injection window keep their data unchanged.
- R3: For an accepted frame, the output bytes at positions P to P+9 carry the correction word (high byte first) followed by the 64-bit stamp (high byte first). P is counted from 0 at the first byte.
- R4: P equals the anchor plus the signed static offset. The cfgAnchor encoding is 0 = frame start (0), 1 = frame end (inFrameLen), 2 = inL3Off, 3 = inL4Off.
- R5: The correction word is the bitwise complement of the end-around-carry folded 16-bit sum of the four stamp words. The ones'-complement sum of the ten output bytes, taken as big-endian words, is 0xFFFF.
- R6: With cfgLastByte = 0, the stamp is the timeNow value present in the cycle the first input byte is accepted. With cfgLastByte = 1, the stamp is that value plus inFrameLen - 1.
- R7: A frame is requested when inInjEn at its first byte is 1 or cfgAlways is 1. A frame with neither set passes unmodified and raises no injErr.
- R8: P must have the same parity as the region start. The region start is inL3Off for anchor 2, inL4Off for anchor 3, and 0 for anchors 0 and 1. A requested frame with odd distance passes unmodified with injErr.
- R9: A requested frame needs 0 <= P <= inFrameLen - 14. Outside that range it passes unmodified with injErr.
- R10: injErr is a single-cycle pulse that coincides with outSof of the rejected frame, and it is never high in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inSof | input | 1 | First byte of frame |
| inEof | input | 1 | Last byte of frame |
| inInjEn | input | 1 | Per-frame injection request, sampled with the first byte |
| inL3Off | input | LEN_W | Layer 3 header start, in bytes from the frame start |
| inL4Off | input | LEN_W | Layer 4 header start, in bytes from the frame start |
| inFrameLen | input | LEN_W | Frame length in bytes, including FCS |
| timeNow | input | 64 | Free-running time counter |
| cfgAnchor | input | 2 | Anchor select (see R4) |
| cfgStaticOff | input | OFF_W | Signed byte offset added to the anchor |
| cfgLastByte | input | 1 | 1 = last-byte stamp, 0 = first-byte stamp |
| cfgAlways | input | 1 | Inject into every frame |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outSof | output | 1 | First byte of frame |
| outEof | output | 1 | Last byte of frame |
| injErr | output | 1 | Rejected-position pulse |

## Verification
A wrong armed flag or a stale stored position shows up as a bad byte inside the same frame. The window's position or content is wrong, or the error pulse is missing, and this is visible no later than the tenth byte after the intended position. A wrong byte counter or stamp register is caught on the very next frame, because the bench model predicts every output byte of every cycle, including idle cycles. The stamp base is set close to a 16-bit carry, so that a fold error in the correction appears as a bad ten-byte sum.

// File: rtl/tsinj_pkg.sv
package tsinj_pkg;

  typedef enum logic [1:0] {
    ANCHOR_START = 2'd0,
    ANCHOR_END   = 2'd1,
    ANCHOR_L3    = 2'd2,
    ANCHOR_L4    = 2'd3
  } anchor_e;

  localparam int FIELD_BYTES = 10;  // correction word + 64-bit stamp
  localparam int GUARD_BYTES = 14;  // field plus trailing FCS

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;  // first byte of a frame accepted this cycle
    logic       replace;  // current byte lies in the injection field
    logic [3:0] sel;      // byte index inside the field
    logic       reject;   // requested frame with an unusable position
  } ctrl_t;

  // complement of the end-around-carry sum of four 16-bit words
  function automatic logic [15:0] neutralWord(input logic [63:0] stamp);
    logic [17:0] raw;
    logic [16:0] once;
    logic [15:0] twice;
    raw   = 18'(stamp[63:48]) + 18'(stamp[47:32]) + 18'(stamp[31:16]) + 18'(stamp[15:0]);
    once  = 17'(raw[15:0]) + 17'(raw[17:16]);
    twice = once[15:0] + 16'(once[16]);
    return ~twice;
  endfunction

endpackage

// File: rtl/tsinj_ctrl.sv
module tsinj_ctrl
  import tsinj_pkg::*;
#(
  parameter int LEN_W = 14,
  parameter int OFF_W = 15
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    inSof,
  input  logic                    inInjEn,
  input  logic [LEN_W-1:0]        inL3Off,
  input  logic [LEN_W-1:0]        inL4Off,
  input  logic [LEN_W-1:0]        inFrameLen,
  input  logic [1:0]              cfgAnchor,
  input  logic signed [OFF_W-1:0] cfgStaticOff,
  input  logic                    cfgAlways,
  output ctrl_t                   strobe
);

  localparam int PW = LEN_W + 3;
  localparam logic signed [PW-1:0] GUARD = PW'(GUARD_BYTES);
  localparam logic [LEN_W-1:0] FIELD_LEN = LEN_W'(FIELD_BYTES);

  logic signed [PW-1:0] anchorBase, alignRef, offExt, posNow, lenExt;
  logic                 startNow, reqNow, inRange, aligned, okNow;
  logic                 armedReg;
  logic [LEN_W-1:0]     posReg, cntReg;
  logic                 curArmed;
  logic [LEN_W-1:0]     curPos, idx, fieldIdx;

  always_comb begin
    unique case (anchor_e'(cfgAnchor))
      ANCHOR_START: begin anchorBase = '0;                          alignRef = '0; end
      ANCHOR_END:   begin anchorBase = $signed({3'b000, inFrameLen}); alignRef = '0; end
      ANCHOR_L3:    begin anchorBase = $signed({3'b000, inL3Off});    alignRef = $signed({3'b000, inL3Off}); end
      default:      begin anchorBase = $signed({3'b000, inL4Off});    alignRef = $signed({3'b000, inL4Off}); end
    endcase
  end

  assign offExt   = $signed({{(PW-OFF_W){cfgStaticOff[OFF_W-1]}}, cfgStaticOff});
  assign lenExt   = $signed({3'b000, inFrameLen});
  assign posNow   = anchorBase + offExt;
  assign startNow = inValid && inSof;
  assign reqNow   = inInjEn || cfgAlways;
  assign inRange  = !posNow[PW-1] && ((posNow + GUARD) <= lenExt);
  assign aligned  = (posNow[0] == alignRef[0]);
  assign okNow    = reqNow && inRange && aligned;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedReg <= 1'b0;
      posReg   <= '0;
      cntReg   <= '0;
    end else begin
      if (startNow) begin
        armedReg <= okNow;
        posReg   <= posNow[LEN_W-1:0];
      end
      if (inValid) cntReg <= startNow ? LEN_W'(1) : cntReg + LEN_W'(1);
    end
  end

  assign curArmed = startNow ? okNow : armedReg;
  assign curPos   = startNow ? posNow[LEN_W-1:0] : posReg;
  assign idx      = startNow ? '0 : cntReg;
  assign fieldIdx = idx - curPos;

  always_comb begin
    strobe.capture = startNow;
    strobe.replace = inValid && curArmed && (idx >= curPos) && (fieldIdx < FIELD_LEN);
    strobe.sel     = fieldIdx[3:0];
    strobe.reject  = startNow && reqNow && !(inRange && aligned);
  end

endmodule

// File: rtl/tsinj_datapath.sv
module tsinj_datapath
  import tsinj_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            strobe,
  input  logic             inValid,
  input  logic [7:0]       inData,
  input  logic             inSof,
  input  logic             inEof,
  input  logic [LEN_W-1:0] inFrameLen,
  input  logic [63:0]      timeNow,
  input  logic             cfgLastByte,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outSof,
  output logic             outEof,
  output logic             injErr
);

  logic [63:0] stampNow, stampReg, stampUse;
  logic [15:0] corrWord;
  logic [79:0] field;
  logic [7:0]  fieldBytes [FIELD_BYTES];
  logic [7:0]  injByte;

  assign stampNow = cfgLastByte ? (timeNow + 64'(inFrameLen) - 64'd1) : timeNow;
  assign stampUse = strobe.capture ? stampNow : stampReg;
  assign corrWord = neutralWord(stampUse);
  assign field    = {corrWord, stampUse};

  for (genvar g = 0; g < FIELD_BYTES; g++) begin : g_bytes
    assign fieldBytes[g] = field[8*(FIELD_BYTES-1-g) +: 8];
  end

  always_comb begin
    injByte = 8'h00;
    for (int k = 0; k < FIELD_BYTES; k++)
      if (strobe.sel == 4'(k)) injByte = fieldBytes[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stampReg <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outSof   <= 1'b0;
      outEof   <= 1'b0;
      injErr   <= 1'b0;
    end else begin
      if (strobe.capture) stampReg <= stampNow;
      outValid <= inValid;
      outData  <= strobe.replace ? injByte : inData;
      outSof   <= inValid && inSof;
      outEof   <= inValid && inEof;
      injErr   <= strobe.reject;
    end
  end

endmodule

// File: rtl/tsinj_top.sv
module tsinj_top
  import tsinj_pkg::*;
#(
  parameter int LEN_W = 14,
  parameter int OFF_W = LEN_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [7:0]              inData,
  input  logic                    inSof,
  input  logic                    inEof,
  input  logic                    inInjEn,
  input  logic [LEN_W-1:0]        inL3Off,
  input  logic [LEN_W-1:0]        inL4Off,
  input  logic [LEN_W-1:0]        inFrameLen,
  input  logic [63:0]             timeNow,
  input  logic [1:0]              cfgAnchor,
  input  logic signed [OFF_W-1:0] cfgStaticOff,
  input  logic                    cfgLastByte,
  input  logic                    cfgAlways,
  output logic                    outValid,
  output logic [7:0]              outData,
  output logic                    outSof,
  output logic                    outEof,
  output logic                    injErr
);

  ctrl_t strobe;

  tsinj_ctrl #(.LEN_W(LEN_W), .OFF_W(OFF_W)) u_ctrl (
    .clk, .rstN, .inValid, .inSof, .inInjEn, .inL3Off, .inL4Off,
    .inFrameLen, .cfgAnchor, .cfgStaticOff, .cfgAlways, .strobe
  );

  tsinj_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk, .rstN, .strobe, .inValid, .inData, .inSof, .inEof, .inFrameLen,
    .timeNow, .cfgLastByte, .outValid, .outData, .outSof, .outEof, .injErr
  );

endmodule

// File: rtl/tsinj_checker.sv
module tsinj_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inSof,
  input logic       inEof,
  input logic       inInjEn,
  input logic       cfgAlways,
  input logic       outValid,
  input logic       outSof,
  input logic       outEof,
  input logic       injErr
);

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_sof_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof) |=> outSof);
  assert_eof_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inEof) |=> outEof);
  assert_err_on_sof_R10: assert property (@(posedge clk) disable iff (!rstN)
    injErr |-> (outValid && outSof));
  assert_no_req_no_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof && !inInjEn && !cfgAlways) |=> !injErr);
  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    injErr |=> !injErr);

endmodule

bind tsinj_top tsinj_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
  .inInjEn(inInjEn), .cfgAlways(cfgAlways), .outValid(outValid),
  .outSof(outSof), .outEof(outEof), .injErr(injErr)
);

// File: tb/tb_tsinj_top.sv
`timescale 1ns/1ps
module tb_tsinj_top;
  localparam int LEN_W = 14;
  localparam int OFF_W = LEN_W + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 0, inSof = 0, inEof = 0, inInjEn = 0;
  logic [7:0] inData = 0;
  logic [LEN_W-1:0] inL3Off = 0, inL4Off = 0, inFrameLen = 0;
  logic [63:0] timeNow = 64'hFFFF_FFF0_FFFF_FF80;
  logic [1:0] cfgAnchor = 0;
  logic signed [OFF_W-1:0] cfgStaticOff = 0;
  logic cfgLastByte = 0, cfgAlways = 0;
  logic outValid, outSof, outEof, injErr;
  logic [7:0] outData;

  int checks = 0, fails = 0;
  bit done = 0;

  // pending expectation for the next sample
  bit eValid = 0, eSof = 0, eEof = 0, eErr = 0;
  bit [7:0] eData = 0;
  string eTag = "R1";

  always #2.5 clk = ~clk;
  always @(posedge clk) timeNow <= timeNow + 64'd1;

  tsinj_top #(.LEN_W(LEN_W), .OFF_W(OFF_W)) dut (.*);

  task automatic check(string tag, bit ok, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareOut();
    logic [11:0] a, e;
    a = {outValid, outSof, outEof, injErr, (outValid ? outData : 8'h00)};
    e = {eValid, eSof, eEof, eErr, (eValid ? eData : 8'h00)};
    check(eTag, a === e, 64'(a), 64'(e));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareOut();
      inValid = 0; inSof = 0; inEof = 0; inInjEn = 0;
      eValid = 0; eSof = 0; eEof = 0; eErr = 0; eData = 0;
    end
  endtask

  function automatic bit [15:0] onesSum(bit [15:0] a, bit [15:0] b);
    int s;
    s = int'(a) + int'(b);
    if (s > 65535) s = s - 65535;
    return 16'(s);
  endfunction

  task automatic frame(string tag, int len, bit inj, int l3, int l4,
                       int anc, int off, bit last, bit alw);
    int pos, base, ref_, okF;
    bit [7:0] pay [0:255];
    bit [7:0] fld [0:9];
    bit [7:0] act [0:9];
    bit [63:0] st;
    bit [15:0] sum, corr;
    cfgAnchor = 2'(anc); cfgStaticOff = OFF_W'(off);
    cfgLastByte = last; cfgAlways = alw;
    base = (anc == 0) ? 0 : (anc == 1) ? len : (anc == 2) ? l3 : l4;
    ref_ = (anc == 2) ? l3 : (anc == 3) ? l4 : 0;
    pos = base + off;
    okF = (inj || alw) && pos >= 0 && pos + 14 <= len && (((pos - ref_) & 1) == 0);
    for (int i = 0; i < len; i++)
      pay[i] = (okF && i >= pos && i < pos + 10) ? 8'h00 : 8'((i * 29 + len) | 1);
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      compareOut();
      if (okF && i >= 1 && (i - 1) >= pos && (i - 1) < pos + 10) act[i-1-pos] = outData;
      if (i == 0) begin
        st = last ? timeNow + 64'(len) - 64'd1 : timeNow;
        sum = 16'h0;
        for (int w = 0; w < 4; w++) sum = onesSum(sum, st[16*w +: 16]);
        corr = ~sum;
        fld[0] = corr[15:8]; fld[1] = corr[7:0];
        for (int b = 0; b < 8; b++) fld[2+b] = st[63-8*b -: 8];
      end
      if (i < len) begin
        inValid = 1; inSof = (i == 0); inEof = (i == len - 1); inData = pay[i];
        inInjEn = (i == 0) ? inj : 1'b0;
        inL3Off = LEN_W'(l3); inL4Off = LEN_W'(l4); inFrameLen = LEN_W'(len);
        eValid = 1; eSof = (i == 0); eEof = (i == len - 1);
        eErr = (i == 0) && (inj || alw) && !okF;
        eData = (okF && i >= pos && i < pos + 10) ? fld[i - pos] : pay[i];
        eTag = tag;
      end else begin
        inValid = 0; inSof = 0; inEof = 0; inInjEn = 0;
        eValid = 0; eSof = 0; eEof = 0; eErr = 0; eData = 0;
      end
    end
    if (okF) begin  // R5 neutral sum over actual output field
      sum = 16'h0;
      for (int w = 0; w < 5; w++) sum = onesSum(sum, {act[2*w], act[2*w+1]});
      check("R5 field sum", sum == 16'hFFFF, 64'(sum), 64'hFFFF);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    // R1: outputs low during reset and in the first cycle after release
    eTag = "R1";
    repeat (3) @(negedge clk);
    compareOut();
    rstN = 1'b1;
    idle(2);
    // R3 R4 R6: frame-start anchor, first-byte stamp
    frame("R3 start anchor", 64, 1, 14, 34, 0, 0, 0, 0);
    idle(2);
    // R4: frame-end anchor, offset -20
    frame("R4 end anchor -20", 60, 1, 14, 34, 1, -20, 0, 0);
    idle(1);
    frame("R4 L3 anchor", 70, 1, 14, 34, 2, 2, 0, 0);
    frame("R4 L4 anchor", 80, 1, 14, 34, 3, 8, 0, 0);
    idle(3);
    // R6: last-byte stamp
    frame("R6 last-byte stamp", 90, 1, 14, 34, 0, 6, 1, 0);
    // R7: not requested, then globally requested
    frame("R7 no request", 64, 0, 14, 34, 0, 4, 0, 0);
    frame("R7 global inject", 64, 0, 14, 34, 1, -24, 0, 1);
    idle(2);
    // R8: odd distance from region start
    frame("R8 misaligned L3", 64, 1, 14, 34, 2, 3, 0, 0);
    frame("R8 misaligned start", 64, 1, 14, 34, 0, 5, 0, 0);
    frame("R8 aligned odd L4", 64, 1, 14, 33, 3, 1, 0, 0);
    // R9: range limits
    frame("R9 end -13 too late", 64, 1, 14, 34, 1, -13, 0, 0);
    frame("R9 end -14 boundary", 64, 1, 14, 34, 1, -14, 1, 0);
    frame("R9 negative position", 64, 1, 14, 34, 0, -2, 0, 0);
    frame("R9 minimum frame", 14, 1, 0, 0, 0, 0, 0, 0);
    // R10: rejected then accepted, back to back
    frame("R10 reject pulse", 40, 1, 14, 34, 1, -3, 0, 0);
    frame("R10 following ok", 40, 1, 14, 34, 0, 10, 0, 0);
    // R2: plain traffic after the run
    frame("R2 passthrough", 30, 0, 14, 34, 0, 0, 0, 0);
    idle(3);
    done = 1;
    finishRun();
  end

endmodule